// File: doc/BRIEF.md
# Triggered Fixed-Length Sample Packetiser

This block sits on a free-running ADC sample stream and cuts it into fixed-length packets on demand. An external trigger pin, asynchronous to the sample clock, is brought into the clock domain. Each new rising edge of it opens a capture window. Inside the window, every valid sample is passed to an AXI4-Stream output, in order and with none lost. Once the packet holds its full count, the final beat carries TLAST and the window closes. The block then waits for the next edge. No software handshake or acknowledgement is needed, and no idle cycle is forced between packets.

The requested length comes from a configuration input. It is rounded up to the next multiple of a power-of-two alignment, 64 samples by default, so that each packet fills whole write bursts downstream. For example, a request of 18750 samples, which is 300 µs at 62.5 MS/s, becomes 18752. A request of zero gives one alignment unit. Samples that arrive while the window is closed are dropped. The output is one register stage behind the input stream.

Top module: `trig_pkt_gate`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, m_tvalid and m_tlast are low and m_tdata is zero.
- R2: The trigger passes through a two-flop synchroniser. If trig_in is first sampled high at clock edge k after being low, the first sample that can be forwarded is the one presented at edge k+3. That sample appears on the outputs after edge k+3.
- R3: Each window forwards exactly L samples. L is pkt_len rounded up to the next multiple of 2^ALIGN_LOG2, and a pkt_len of 0 gives L = 2^ALIGN_LOG2.
- R4: m_tlast is high on the L-th beat of a packet and on no other beat. m_tlast is never high without m_tvalid.
- R5: While no window is open, samples are discarded and m_tvalid stays low.
- R6: Inside a window, m_tvalid in a cycle equals s_valid one cycle earlier. m_tdata carries that sample, so the samples leave in arrival order with none skipped.
- R7: A rising trigger edge seen while a window is open is ignored, including in the cycle that forwards the final sample. A trigger held high produces only one packet.
- R8: A rising edge seen in the first cycle after the final sample opens a new window, with no extra dead cycle.
- R9: pkt_len is sampled only when a window opens. Changing it during a packet does not change that packet's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | External trigger, asynchronous |
| pkt_len | input | LEN_W | Requested packet length in samples |
| s_data | input | DATA_W | ADC sample |
| s_valid | input | 1 | ADC sample valid |
| m_tdata | output | DATA_W | Forwarded sample |
| m_tvalid | output | 1 | Forwarded sample valid |
| m_tlast | output | 1 | Final beat of a packet |

## Verification
The sharpest collision is a new trigger edge landing in the same cycle as a packet's final sample. The closing logic and the opening logic then both want the state register. The bench times a one-cycle trigger pulse so that its synchronised edge coincides with the last forwarded sample, and it expects no second packet. It then moves the pulse one cycle later and expects a second full-length packet whose first sample directly follows the previous packet's last. A second overlap, a length change that arrives mid-packet, is judged by counting the beats of that packet against the length latched when its window opened.

// File: rtl/trig_gate_pkg.sv
package trig_gate_pkg;
  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_OPEN = 1'b1
  } gate_state_e;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // synchroniser chain followed by one history flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/len_round.sv
module len_round #(
  parameter int LEN_W      = 15,
  parameter int ALIGN_LOG2 = 6
) (
  input  logic [LEN_W-1:0] req_len,
  output logic [LEN_W:0]   eff_len
);
  localparam int            ALIGN = 1 << ALIGN_LOG2;
  localparam logic [LEN_W:0] ADDEND = (LEN_W+1)'(ALIGN - 1);
  localparam logic [LEN_W:0] MASK   = ~ADDEND;
  localparam logic [LEN_W:0] MINLEN = (LEN_W+1)'(ALIGN);

  logic [LEN_W:0] sum;

  always_comb begin
    sum = {1'b0, req_len} + ADDEND;
    if (req_len == '0) eff_len = MINLEN;
    else               eff_len = sum & MASK;
  end
endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import trig_gate_pkg::*;
#(
  parameter int LEN_W = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rise,
  input  logic [LEN_W:0] eff_len,
  input  logic           s_valid,
  output logic           fwd,
  output logic           last,
  output logic           is_open
);
  gate_state_e    state_q, state_d;
  logic [LEN_W:0] cnt_q, cnt_d;
  logic [LEN_W:0] len_q;
  logic           len_load;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    len_load = 1'b0;
    is_open  = (state_q == GATE_OPEN);
    fwd      = is_open & s_valid;
    last     = fwd & (cnt_q == len_q - 1'b1);
    case (state_q)
      GATE_IDLE: begin
        if (rise) begin
          state_d  = GATE_OPEN;
          cnt_d    = '0;
          len_load = 1'b1;
        end
      end
      GATE_OPEN: begin
        if (last) begin
          state_d = GATE_IDLE;
          cnt_d   = '0;
        end else if (fwd) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (len_load) len_q <= eff_len;
    end
  end
endmodule

// File: rtl/trig_pkt_gate.sv
module trig_pkt_gate #(
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 15,
  parameter int ALIGN_LOG2 = 6,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  output logic              m_tlast
);
  logic           trig_rise;
  logic [LEN_W:0] eff_len;
  logic           fwd;
  logic           last;
  logic           win_open;

  trig_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trig_in),
    .rise     (trig_rise)
  );

  len_round #(.LEN_W(LEN_W), .ALIGN_LOG2(ALIGN_LOG2)) u_round (
    .req_len (pkt_len),
    .eff_len (eff_len)
  );

  gate_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (trig_rise),
    .eff_len (eff_len),
    .s_valid (s_valid),
    .fwd     (fwd),
    .last    (last),
    .is_open (win_open)
  );

  // registered output stage; data register only loads on a forwarded beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
      m_tdata  <= '0;
    end else begin
      m_tvalid <= fwd;
      m_tlast  <= last;
      if (fwd) m_tdata <= s_data;
    end
  end
endmodule

// File: rtl/trig_pkt_gate_chk.sv
module trig_pkt_gate_chk #(
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 15,
  parameter int ALIGN_LOG2 = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic [DATA_W-1:0] s_data,
  input logic              m_tvalid,
  input logic              m_tlast,
  input logic [DATA_W-1:0] m_tdata,
  input logic              win_open
);
  localparam logic [LEN_W+1:0] LOWMASK = (LEN_W+2)'((1 << ALIGN_LOG2) - 1);

  logic [LEN_W+1:0] beat_cnt;
  logic [LEN_W+1:0] beat_nxt;
  logic             last_aligned;

  assign beat_nxt     = beat_cnt + 1'b1;
  assign last_aligned = ((beat_nxt & LOWMASK) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beat_cnt <= '0;
    else if (m_tlast)  beat_cnt <= '0;
    else if (m_tvalid) beat_cnt <= beat_nxt;
  end

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n) m_tlast |-> m_tvalid); // R4
  AST_PKT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) m_tlast |-> last_aligned); // R3
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) m_tvalid |-> $past(s_valid)); // R6
  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n) m_tvalid |-> (m_tdata == $past(s_data))); // R6
  AST_CLOSED_DISCARD: assert property (@(posedge clk) disable iff (!rst_n) !win_open |=> !m_tvalid); // R5
endmodule

bind trig_pkt_gate trig_pkt_gate_chk #(
  .DATA_W     (DATA_W),
  .LEN_W      (LEN_W),
  .ALIGN_LOG2 (ALIGN_LOG2)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_data   (s_data),
  .m_tvalid (m_tvalid),
  .m_tlast  (m_tlast),
  .m_tdata  (m_tdata),
  .win_open (win_open)
);

// File: tb/tb_trig_pkt_gate.sv
`timescale 1ns/100ps
module tb_trig_pkt_gate;
  localparam int DW = 16;
  localparam int LW = 5;
  localparam int AL = 2;

  logic          clk;
  logic          rst_n;
  logic          trig_in;
  logic [LW-1:0] pkt_len;
  logic [DW-1:0] s_data;
  logic          s_valid;
  logic [DW-1:0] m_tdata;
  logic          m_tvalid;
  logic          m_tlast;

  int errors = 0;
  int checks = 0;
  int exp_len = 4;
  int exp_first = 0;
  int beat_idx = 0;
  int pkts = 0;
  int beats = 0;
  int prev_data = 0;
  int vcnt = 1;
  int cd = -1;
  bit arm = 0;
  bit trig_prev = 0;
  bit mon_on = 0;

  trig_pkt_gate #(.DATA_W(DW), .LEN_W(LW), .ALIGN_LOG2(AL)) dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .pkt_len(pkt_len),
    .s_data(s_data), .s_valid(s_valid),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rnd(input int len);
    if (len == 0) return 1 << AL;
    return ((len + (1 << AL) - 1) >> AL) << AL;
  endfunction

  // one input cycle, driven at the falling edge
  task automatic cyc(input bit trig, input bit v);
    @(negedge clk);
    trig_in = trig;
    s_valid = v;
    if (v) begin
      s_data = DW'(vcnt);
    end
    if (trig && !trig_prev && arm) cd = 0;
    if (cd >= 0) begin
      if (cd >= 3 && v) begin
        exp_first = vcnt;
        cd = -1;
        arm = 0;
      end else begin
        cd++;
      end
    end
    if (v) vcnt++;
    trig_prev = trig;
  endtask

  // output monitor, one time unit after the rising edge
  always @(posedge clk) begin
    #1;
    if (mon_on && m_tvalid) begin
      beats++;
      if (beat_idx == 0)
        chk(int'(m_tdata) == exp_first, "R2 first sample", int'(m_tdata), exp_first);
      else
        chk(int'(m_tdata) == prev_data + 1, "R6 in-order data", int'(m_tdata), prev_data + 1);
      chk(m_tlast == (beat_idx == exp_len - 1), "R4 tlast position", int'(m_tlast), int'(beat_idx == exp_len - 1));
      prev_data = int'(m_tdata);
      if (m_tlast) begin
        pkts++;
        beat_idx = 0;
      end else begin
        beat_idx++;
      end
    end
  end

  task automatic run_pkt(input int len, input int gap);
    int p0;
    int b0;
    pkt_len = LW'(len);
    exp_len = rnd(len);
    arm = 1;
    p0 = pkts;
    b0 = beats;
    cyc(1'b1, 1'b1);
    for (int i = 1; i < exp_len * 2 + 12; i++)
      cyc(1'b0, (gap == 0) ? 1'b1 : ((i % gap) != 0));
    chk(pkts == p0 + 1, "R3 one packet", pkts - p0, 1);
    chk(beats - b0 == exp_len, "R3 rounded length", beats - b0, exp_len);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int p0;
    int b0;
    rst_n = 1'b0;
    trig_in = 1'b0;
    pkt_len = '0;
    s_data = '0;
    s_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!m_tvalid && !m_tlast && m_tdata == '0, "R1 reset outputs", int'(m_tvalid) + int'(m_tlast) + int'(m_tdata), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(!m_tvalid && !m_tlast && m_tdata == '0, "R1 after release", int'(m_tvalid) + int'(m_tlast) + int'(m_tdata), 0);
    mon_on = 1;

    // R5: valid samples with no trigger are discarded
    b0 = beats;
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b1);
    chk(beats == b0, "R5 no trigger no beats", beats - b0, 0);

    // R3: sweep every requested length with a continuous stream
    for (int len = 0; len < (1 << LW); len++) run_pkt(len, 0);

    // R6: gaps in the input valid
    run_pkt(7, 3);
    run_pkt(13, 2);
    run_pkt(2, 4);
    run_pkt(0, 5);

    // R7: pulse during an open window is ignored
    pkt_len = LW'(8); exp_len = 8; arm = 1; p0 = pkts; b0 = beats;
    for (int i = 0; i < 40; i++) cyc((i == 0) || (i == 6), 1'b1);
    chk(pkts == p0 + 1, "R7 mid-packet edge ignored", pkts - p0, 1);
    chk(beats - b0 == 8, "R7 length kept", beats - b0, 8);

    // R7: trigger held high gives one packet only
    pkt_len = LW'(4); exp_len = 4; arm = 1; p0 = pkts; b0 = beats;
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b1);
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1);
    chk(pkts == p0 + 1, "R7 held trigger one packet", pkts - p0, 1);
    chk(beats - b0 == 4, "R7 held trigger beats", beats - b0, 4);

    // R7: edge coinciding with the final sample is ignored
    pkt_len = LW'(8); exp_len = 8; arm = 1; p0 = pkts; b0 = beats;
    for (int i = 0; i < 40; i++) cyc((i == 0) || (i == 8), 1'b1);
    chk(pkts == p0 + 1, "R7 edge on last beat ignored", pkts - p0, 1);
    chk(beats - b0 == 8, "R7 edge on last beat beats", beats - b0, 8);

    // R8: edge one cycle after the final sample opens at once
    pkt_len = LW'(8); exp_len = 8; arm = 1; p0 = pkts; b0 = beats;
    for (int i = 0; i < 40; i++) begin
      if (i == 9) arm = 1;
      cyc((i == 0) || (i == 9), 1'b1);
    end
    chk(pkts == p0 + 2, "R8 back-to-back packets", pkts - p0, 2);
    chk(beats - b0 == 16, "R8 back-to-back beats", beats - b0, 16);

    // R9: length change during a packet has no effect
    pkt_len = LW'(5); exp_len = 8; arm = 1; p0 = pkts; b0 = beats;
    for (int i = 0; i < 40; i++) begin
      if (i == 4) pkt_len = LW'(1);
      cyc(i == 0, 1'b1);
    end
    chk(pkts == p0 + 1, "R9 one packet", pkts - p0, 1);
    chk(beats - b0 == 8, "R9 latched length", beats - b0, 8);

    // R9: the new length applies to the next packet
    run_pkt(1, 0);

    finish_run();
  end
endmodule